// File: doc/BRIEF.md
# Separable Dilated Depthwise Convolution Engine

This engine filters one channel plane of a feature map at a time with a 3×3 depthwise window. The window is factored into a vertical three-tap kernel followed by a horizontal three-tap kernel, so each output pixel costs six multiplications instead of nine. Each kernel tap is spaced by a run-time dilation of 1, 2 or 3. The plane is zero-padded, so the output plane has exactly the input's width and height, and channels never mix.

Software first loads a vertical and a horizontal coefficient triple for each channel through a write port. A start pulse then latches the plane width, the plane height, the dilation and a channel index. The block copies that channel's six coefficients into working registers. Pixels arrive in raster order under a valid/ready handshake, and results leave in the same raster order at full precision. A separate requantization unit narrows them afterwards.

Internally the engine walks a grid that is d columns wider and d rows taller than the plane. Grid steps outside the image need no input and advance one per cycle. As a result, the output for pixel (y, x) appears a fixed two cycles after the grid step that accepts input pixel (y+d, x+d).

Top module: `dadc_engine`

## Requirements
- R1: Each output uses only the six coefficients stored for the channel given at start; no other channel's coefficients take part.
- R2: With vertical taps kv0..kv2 (tap codes 0..2, top to bottom) and horizontal taps kh0..kh2 (tap codes 3..5, left to right), each output equals out(y,x) = Σj khj·v(y, x+(j−1)d), where v(y,x) = Σi kvi·p(y+(i−1)d, x).
- R3: The dilation d spaces the taps d rows apart vertically and d columns apart horizontally, for d in {1, 2, 3}.
- R4: Pixels outside the plane count as zero, and a frame yields exactly width×height outputs for any width from 1 to MAX_W.
- R5: Width, height, dilation and channel are latched only by a start pulse while idle; changing these inputs, or pulsing start, during a frame has no effect on that frame.
- R6: Coefficient writes made during a frame do not change that frame's outputs.
- R7: Outputs leave in raster order. Output (y,x) appears two cycles after the grid step that accepts input (y+d, x+d), on a grid of width+d columns by height+d rows.
- R8: pix_ready_o is high only while the engine is waiting for an in-image pixel. A frame accepts exactly width×height pixels and tolerates gaps in pix_valid_i.
- R9: frame_done_o pulses for one cycle, in the cycle after the last output; busy_o falls together with it.
- R10: The vertical sum is kept at 26 bits and the output at 36 bits, both signed, with no saturation or truncation, even at the extreme codes −32768 and −128.
- R11: A dilation code of 0 is treated as dilation 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a frame (accepted only when idle) |
| width_i | input | $clog2(MAX_W+1) | Plane width, 1..MAX_W |
| height_i | input | $clog2(MAX_H+1) | Plane height, 1..MAX_H |
| dil_i | input | 2 | Dilation code, 1..3 (0 means 1) |
| chan_i | input | $clog2(NCH) | Channel whose coefficients are used |
| kwr_en_i | input | 1 | Coefficient write strobe |
| kwr_chan_i | input | $clog2(NCH) | Channel of the coefficient write |
| kwr_tap_i | input | 3 | Tap code 0..5 (0..2 vertical top to bottom, 3..5 horizontal left to right) |
| kwr_data_i | input | 8 | Signed coefficient |
| pix_i | input | 16 | Signed input pixel |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_ready_o | output | 1 | Engine accepts an in-image pixel |
| busy_o | output | 1 | Frame in progress, from start until done |
| out_o | output | 36 | Signed output pixel |
| out_valid_o | output | 1 | Output pixel valid |
| frame_done_o | output | 1 | One-cycle pulse after the last output |

## Verification
The bench builds the engine with MAX_W = 32, MAX_H = 32 and NCH = 8, which keeps the line buffers and the coefficient bank small. With these values a plane as wide as the line buffer is reachable in a short run, as are planes narrower than one dilation step. Every dilation runs at least once on a plane where border pixels dominate. Channel selection is exercised across several of the eight banks, and a channel's coefficients are rewritten in the middle of a frame.

// File: rtl/dadc_pkg.sv
package dadc_pkg;
  localparam int PIX_W   = 16;
  localparam int COEF_W  = 8;
  localparam int VSUM_W  = 26;
  localparam int OSUM_W  = 36;
  localparam int DIL_MAX = 3;
  localparam int NTAPS   = 6;

  typedef logic signed [PIX_W-1:0]  pix_t;
  typedef logic signed [COEF_W-1:0] coef_t;
  typedef logic signed [VSUM_W-1:0] vsum_t;
  typedef logic signed [OSUM_W-1:0] osum_t;
endpackage

// File: rtl/dadc_kernel_bank.sv
module dadc_kernel_bank
  import dadc_pkg::*;
#(
  parameter int NCH = 64,
  localparam int CHW = $clog2(NCH)
) (
  input  logic                          clk_i,
  input  logic                          wr_en_i,
  input  logic [CHW-1:0]                wr_chan_i,
  input  logic [2:0]                    wr_tap_i,
  input  logic [COEF_W-1:0]             wr_data_i,
  input  logic [CHW-1:0]                rd_chan_i,
  output logic [NTAPS-1:0][COEF_W-1:0]  rd_kset_o
);
  logic [COEF_W-1:0] mem_q [NCH*NTAPS];

  always_ff @(posedge clk_i) begin
    if (wr_en_i && int'(wr_tap_i) < NTAPS && int'(wr_chan_i) < NCH)
      mem_q[int'(wr_chan_i)*NTAPS + int'(wr_tap_i)] <= wr_data_i;
  end

  for (genvar t = 0; t < NTAPS; t++) begin : g_rd
    assign rd_kset_o[t] = mem_q[int'(rd_chan_i)*NTAPS + t];
  end
endmodule

// File: rtl/dadc_vert_stage.sv
module dadc_vert_stage
  import dadc_pkg::*;
#(
  parameter int MAX_W = 256,
  localparam int AW = $clog2(MAX_W),
  localparam int SLOTS = 2*DIL_MAX,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          step_i,
  input  logic          row_end_i,
  input  logic [AW-1:0] col_i,
  input  logic          col_ok_i,
  input  logic          top_ok_i,
  input  logic          mid_ok_i,
  input  logic [1:0]    dil_i,
  input  pix_t          pix_i,
  input  coef_t         kv0_i,
  input  coef_t         kv1_i,
  input  coef_t         kv2_i,
  output vsum_t         vsum_o
);
  pix_t           lines_q [SLOTS][MAX_W];
  logic [SW-1:0]  wslot_q, rs_mid, rs_top;
  logic [SW-1:0]  d1, d2;
  pix_t           tap_top, tap_mid, tap_bot;
  vsum_t          vsum;

  assign d1 = SW'(dil_i);
  assign d2 = SW'({dil_i, 1'b0});

  // circular row slots: row r lives in slot r mod SLOTS
  always_comb begin
    rs_mid = (wslot_q >= d1) ? wslot_q - d1 : wslot_q + SW'(SLOTS) - d1;
    rs_top = (wslot_q >= d2) ? wslot_q - d2 : wslot_q + SW'(SLOTS) - d2;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   wslot_q <= '0;
    else if (clear_i)              wslot_q <= '0;
    else if (step_i && row_end_i)  wslot_q <= (wslot_q == SW'(SLOTS-1)) ? '0 : wslot_q + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (step_i && col_ok_i) lines_q[wslot_q][col_i] <= pix_i;
  end

  always_comb begin
    tap_top = (col_ok_i && top_ok_i) ? lines_q[rs_top][col_i] : '0;
    tap_mid = (col_ok_i && mid_ok_i) ? lines_q[rs_mid][col_i] : '0;
    tap_bot = col_ok_i ? pix_i : '0;
    vsum = vsum_t'(kv0_i) * vsum_t'(tap_top)
         + vsum_t'(kv1_i) * vsum_t'(tap_mid)
         + vsum_t'(kv2_i) * vsum_t'(tap_bot);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     vsum_o <= '0;
    else if (step_i) vsum_o <= vsum;
  end
endmodule

// File: rtl/dadc_horz_stage.sv
module dadc_horz_stage
  import dadc_pkg::*;
#(
  localparam int SR_N = 2*DIL_MAX
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       step_i,
  input  vsum_t      vsum_i,
  input  logic       left_ok_i,
  input  logic       emit_i,
  input  logic       last_i,
  input  logic [1:0] dil_i,
  input  coef_t      kh0_i,
  input  coef_t      kh1_i,
  input  coef_t      kh2_i,
  output osum_t      out_o,
  output logic       out_valid_o,
  output logic       out_last_o
);
  vsum_t sr_q [SR_N];
  vsum_t v_left, v_mid;
  osum_t sum;

  always_ff @(posedge clk_i) begin
    if (step_i) begin
      sr_q[0] <= vsum_i;
      for (int k = 1; k < SR_N; k++) sr_q[k] <= sr_q[k-1];
    end
  end

  // newest column is x+d, d steps back is x, 2d steps back is x-d
  always_comb begin
    v_mid  = sr_q[int'(dil_i) - 1];
    v_left = left_ok_i ? sr_q[2*int'(dil_i) - 1] : '0;
    sum = osum_t'(kh0_i) * osum_t'(v_left)
        + osum_t'(kh1_i) * osum_t'(v_mid)
        + osum_t'(kh2_i) * osum_t'(vsum_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_o       <= '0;
      out_valid_o <= 1'b0;
      out_last_o  <= 1'b0;
    end else begin
      out_valid_o <= step_i && emit_i;
      out_last_o  <= step_i && emit_i && last_i;
      if (step_i && emit_i) out_o <= sum;
    end
  end
endmodule

// File: rtl/dadc_engine.sv
module dadc_engine
  import dadc_pkg::*;
#(
  parameter int MAX_W = 256,
  parameter int MAX_H = 256,
  parameter int NCH   = 64,
  localparam int WW  = $clog2(MAX_W+1),
  localparam int HW  = $clog2(MAX_H+1),
  localparam int CHW = $clog2(NCH),
  localparam int AW  = $clog2(MAX_W),
  localparam int CW  = $clog2(MAX_W+DIL_MAX+1),
  localparam int RW  = $clog2(MAX_H+DIL_MAX+1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [WW-1:0]       width_i,
  input  logic [HW-1:0]       height_i,
  input  logic [1:0]          dil_i,
  input  logic [CHW-1:0]      chan_i,
  input  logic                kwr_en_i,
  input  logic [CHW-1:0]      kwr_chan_i,
  input  logic [2:0]          kwr_tap_i,
  input  logic [COEF_W-1:0]   kwr_data_i,
  input  logic [PIX_W-1:0]    pix_i,
  input  logic                pix_valid_i,
  output logic                pix_ready_o,
  output logic                busy_o,
  output logic [OSUM_W-1:0]   out_o,
  output logic                out_valid_o,
  output logic                frame_done_o
);
  logic [NTAPS-1:0][COEF_W-1:0] bank_kset, kset_q;
  logic          busy_q, run_q, start_ok, in_img, step, row_end, last;
  logic [CW-1:0] w_q, c_q, dc;
  logic [RW-1:0] h_q, r_q, dr;
  logic [1:0]    d_q;
  logic          s1_valid_q, s1_left_q, s1_emit_q, s1_last_q, out_last;
  pix_t          pix_in;
  vsum_t         vsum;
  osum_t         osum;

  dadc_kernel_bank #(.NCH(NCH)) u_bank (
    .clk_i, .wr_en_i(kwr_en_i), .wr_chan_i(kwr_chan_i), .wr_tap_i(kwr_tap_i),
    .wr_data_i(kwr_data_i), .rd_chan_i(chan_i), .rd_kset_o(bank_kset)
  );

  assign start_ok = start_i && !busy_q;
  assign dc       = CW'(d_q);
  assign dr       = RW'(d_q);
  assign in_img   = run_q && (c_q < w_q) && (r_q < h_q);
  assign step     = run_q && (in_img ? pix_valid_i : 1'b1);
  assign row_end  = (c_q == w_q + dc - 1'b1);
  assign last     = row_end && (r_q == h_q + dr - 1'b1);
  assign pix_in   = in_img ? pix_t'(pix_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; run_q <= 1'b0;
      w_q <= '0; h_q <= '0; d_q <= 2'd1; kset_q <= '0;
      c_q <= '0; r_q <= '0;
    end else if (start_ok) begin
      busy_q <= 1'b1; run_q <= 1'b1;
      w_q <= CW'(width_i); h_q <= RW'(height_i);
      d_q <= (dil_i == 2'd0) ? 2'd1 : dil_i;
      kset_q <= bank_kset;
      c_q <= '0; r_q <= '0;
    end else begin
      if (frame_done_o) busy_q <= 1'b0;
      if (step) begin
        if (row_end) begin
          c_q <= '0;
          if (last) run_q <= 1'b0;
          else      r_q <= r_q + 1'b1;
        end else c_q <= c_q + 1'b1;
      end
    end
  end

  dadc_vert_stage #(.MAX_W(MAX_W)) u_vert (
    .clk_i, .rst_ni, .clear_i(start_ok), .step_i(step), .row_end_i(row_end),
    .col_i(c_q[AW-1:0]), .col_ok_i(c_q < w_q),
    .top_ok_i(r_q >= RW'({d_q, 1'b0})), .mid_ok_i(r_q >= dr),
    .dil_i(d_q), .pix_i(pix_in),
    .kv0_i($signed(kset_q[0])), .kv1_i($signed(kset_q[1])), .kv2_i($signed(kset_q[2])),
    .vsum_o(vsum)
  );

  // column/row metadata travels alongside the vertical sum
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q <= 1'b0; s1_left_q <= 1'b0; s1_emit_q <= 1'b0; s1_last_q <= 1'b0;
    end else begin
      s1_valid_q <= step;
      if (step) begin
        s1_left_q <= c_q >= CW'({d_q, 1'b0});
        s1_emit_q <= (r_q >= dr) && (c_q >= dc);
        s1_last_q <= last;
      end
    end
  end

  dadc_horz_stage u_horz (
    .clk_i, .rst_ni, .step_i(s1_valid_q), .vsum_i(vsum), .left_ok_i(s1_left_q),
    .emit_i(s1_emit_q), .last_i(s1_last_q), .dil_i(d_q),
    .kh0_i($signed(kset_q[3])), .kh1_i($signed(kset_q[4])), .kh2_i($signed(kset_q[5])),
    .out_o(osum), .out_valid_o(out_valid_o), .out_last_o(out_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) frame_done_o <= 1'b0;
    else         frame_done_o <= out_last;
  end

  assign out_o       = osum;
  assign pix_ready_o = in_img;
  assign busy_o      = busy_q;

  logic [CW+RW-1:0] out_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          out_cnt_q <= '0;
    else if (start_ok)    out_cnt_q <= '0;
    else if (out_valid_o) out_cnt_q <= out_cnt_q + 1'b1;
  end

  // R5
  params_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && $past(busy_q) |-> $stable(w_q) && $stable(h_q) && $stable(d_q) && $stable(kset_q));
  // R4
  out_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_cnt_q < (CW+RW)'(w_q) * (CW+RW)'(h_q));
  // R9
  done_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> $past(out_valid_o) && !out_valid_o);
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o && !busy_o);
  // R8
  ready_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !pix_ready_o);
  // R11
  dil_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> d_q != 2'd0);
endmodule

// File: tb/dadc_engine_bench.sv
module dadc_engine_bench;
  localparam int MW = 32, MH = 32, NC = 8;
  localparam int WW = $clog2(MW+1), HW = $clog2(MH+1), CHW = $clog2(NC);

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic start = 0, kwr_en = 0, pvalid = 0;
  logic [WW-1:0] width = '0;
  logic [HW-1:0] height = '0;
  logic [1:0] dil = 2'd1;
  logic [CHW-1:0] chan = '0, kwr_chan = '0;
  logic [2:0] kwr_tap = '0;
  logic [7:0] kwr_data = '0;
  logic [15:0] pix = '0;
  logic pready, busy, oval, done;
  logic [35:0] out;

  dadc_engine #(.MAX_W(MW), .MAX_H(MH), .NCH(NC)) u_dadc_engine (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .width_i(width), .height_i(height),
    .dil_i(dil), .chan_i(chan), .kwr_en_i(kwr_en), .kwr_chan_i(kwr_chan),
    .kwr_tap_i(kwr_tap), .kwr_data_i(kwr_data), .pix_i(pix), .pix_valid_i(pvalid),
    .pix_ready_o(pready), .busy_o(busy), .out_o(out), .out_valid_o(oval),
    .frame_done_o(done)
  );

  int total = 0, bad = 0;
  int kb [NC][6];
  int img [MW*MH];
  int cw, ch, cd, cc;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic longint p_at(int y, int x);
    if (y < 0 || y >= ch || x < 0 || x >= cw) return 0;
    return longint'(img[y*cw + x]);
  endfunction

  function automatic longint v_at(int y, int x);
    longint s = 0;
    if (x < 0 || x >= cw) return 0;
    for (int i = 0; i < 3; i++) s += longint'(kb[cc][i]) * p_at(y + (i-1)*cd, x);
    return s;
  endfunction

  function automatic longint o_at(int y, int x);
    longint s = 0;
    for (int j = 0; j < 3; j++) s += longint'(kb[cc][3+j]) * v_at(y, x + (j-1)*cd);
    return s;
  endfunction

  task automatic wr_coef(input int c, input int t, input int v);
    @(negedge clk);
    kwr_en = 1; kwr_chan = CHW'(c); kwr_tap = 3'(t); kwr_data = 8'(v);
    @(negedge clk);
    kwr_en = 0;
  endtask

  task automatic load_all();
    for (int c = 0; c < NC; c++)
      for (int t = 0; t < 6; t++) begin
        kb[c][t] = ((c*7 + t*5 + 3) % 19) - 9;
        wr_coef(c, t, kb[c][t]);
      end
  endtask

  task automatic fill(input int w, input int h, input int seed);
    for (int i = 0; i < w*h; i++)
      img[i] = (((i*37 + seed*91) % 211) - 105) * 150;
  endtask

  // mode: 0 plain, 1 gaps in valid, 2 disturb inputs mid-frame
  task automatic run_frame(input string req, input int w, input int h, input int dcode,
                           input int c, input int mode);
    int k = 0, n = 0, cyc = 0;
    bit seen = 0, prev_v = 0;
    cw = w; ch = h; cd = (dcode == 0) ? 1 : dcode; cc = c;
    @(negedge clk);
    width = WW'(w); height = HW'(h); dil = 2'(dcode); chan = CHW'(c); start = 1;
    while (!seen && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      start = 0; kwr_en = 0;
      if (oval) begin
        chk(out == 36'(o_at(n / w, n % w)), req, longint'($signed(out)), o_at(n / w, n % w));
        n++;
      end
      if (done) begin
        seen = 1;
        chk(prev_v && n == w*h, {req, " R4 R9 count/done"}, n, w*h);
        chk(k == w*h, {req, " R8 accepted"}, k, w*h);
      end
      prev_v = oval;
      if (mode == 2 && cyc == 6) begin
        width = 3; height = 2; dil = 2'd3; chan = CHW'((c+1) % NC); start = 1;
        kwr_en = 1; kwr_chan = CHW'(c); kwr_tap = 3'd4; kwr_data = 8'd99;
      end
      if (pready && !(mode == 1 && (cyc % 3 == 1))) begin
        pix = 16'(img[k]); pvalid = 1; k++;
      end else pvalid = 0;
    end
    pvalid = 0;
    chk(seen, {req, " frame done seen"}, 32'(seen), 1);
    @(negedge clk);
    chk(!busy && !done, {req, " R9 idle after done"}, 32'(busy), 0);
  endtask

  task automatic t_reset();
    chk(!busy && !oval && !done && !pready, "reset", {busy, oval, done, pready}, 0);
  endtask

  task automatic t_basic();
    fill(8, 6, 1);  run_frame("R1 R2 R7 d1 ch2", 8, 6, 1, 2, 0);
    fill(7, 5, 2);  run_frame("R1 R2 d1 ch5", 7, 5, 1, 5, 0);
  endtask

  task automatic t_dilation();
    fill(9, 7, 3);  run_frame("R3 R8 d2 gaps", 9, 7, 2, 1, 1);
    fill(10, 9, 4); run_frame("R3 d3", 10, 9, 3, 6, 0);
    fill(2, 2, 5);  run_frame("R4 tiny d3", 2, 2, 3, 3, 0);
    fill(1, 1, 6);  run_frame("R4 single d2", 1, 1, 2, 0, 0);
  endtask

  task automatic t_full_width();
    fill(MW, 3, 7); run_frame("R4 full width d2", MW, 3, 2, 4, 1);
  endtask

  task automatic t_extreme();
    for (int t = 0; t < 6; t++) begin kb[7][t] = -128; wr_coef(7, t, -128); end
    for (int i = 0; i < 16; i++) img[i] = -32768;
    cw = 4; ch = 4;
    run_frame("R10 extreme", 4, 4, 1, 7, 0);
  endtask

  task automatic t_disturb();
    fill(6, 5, 8); run_frame("R5 R6 mid-frame change", 6, 5, 2, 2, 2);
    wr_coef(2, 4, kb[2][4]);
    fill(5, 4, 9); run_frame("R5 next frame", 5, 4, 1, 2, 0);
  endtask

  task automatic t_dil_zero();
    fill(6, 4, 10); run_frame("R11 code0", 6, 4, 0, 3, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    load_all();
    t_basic();
    t_dilation();
    t_full_width();
    t_extreme();
    t_disturb();
    t_dil_zero();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule